// File: doc/BRIEF.md
# Timed Interrupt Mask Gate

This block sits on the request wires between interrupt sources and a processor's interrupt inputs. An unprivileged instruction can ask it to hold back every request line for a short, bounded number of clock cycles. Software uses this to run a short read-modify-write sequence without being interrupted. The window is counted in clock cycles because the gate cannot see when instructions retire. A hardware ceiling clamps the window, so a user task can never hold interrupts off for long.

A second command asks whether the window is still open. After its critical section, software issues this query. If the answer is "open", no interrupt was let through during the sequence, so the sequence completed as one unit. If the answer is "closed", software retries.

Request lines are level-sensitive. A source that raises its line during the window keeps it raised, and the line reaches the processor as soon as the window closes. Priority, vectoring and the processor's own interrupt controller lie outside this block.

Top module: `irq_mask_gate`

The window control is a two-state machine:
- State `GS_IDLE`: the window is closed and the request lines pass through.
- State `GS_MASKED`: the window is open and the request lines are held low.

Its transitions are:
- ARM: `GS_IDLE` to `GS_MASKED`, on an arm command whose clamped count is nonzero.
- RELOAD: `GS_MASKED` to `GS_MASKED`, on an arm command with a nonzero count. The counter is reloaded.
- CANCEL: `GS_MASKED` to `GS_IDLE`, on an arm command with a count of zero.
- TICK: `GS_MASKED` to `GS_MASKED`, when no arm command arrives and the counter is above 1. The counter decrements.
- EXPIRE: `GS_MASKED` to `GS_IDLE`, when no arm command arrives and the counter equals 1.

## Requirements
- R1: While the window is closed, `irq_out` equals `irq_in` in the same cycle, bit for bit.
- R2: An arm command with count C, where 1 <= C <= MAX_WINDOW, is sampled at a clock edge. `irq_out` is then all zeros for exactly C cycles, starting right after that edge.
- R3: An arm command with count 0, issued while the window is closed, opens no window. `irq_out` keeps following `irq_in`, and a later query reads 0.
- R4: An arm command issued while the window is open reloads the counter with the new clamped count. The window then lasts exactly that many cycles from the reload edge. A count of 0 closes the window at once.
- R5: An arm count above MAX_WINDOW (default 64) is clamped to MAX_WINDOW. The counter never exceeds MAX_WINDOW.
- R6: A query sampled at a clock edge produces `rsp_valid`=1 for one cycle after that edge. `rsp_active` is 1 if the window was open at the sampling edge and 0 if it was not. Without a query, `rsp_valid` is 0.
- R7: A request line raised during the window stays 0 at `irq_out` until the counter reaches zero. It appears in the first cycle after the window's last masked cycle.
- R8: During and right after reset, the window is closed, `irq_out` follows `irq_in`, and `rsp_valid` is 0.
- R9: When an arm command and a query are sampled at the same edge, the query reports the window state from before that arm command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_in | input | N_LINES | Level request lines from the sources |
| irq_out | output | N_LINES | Gated request lines to the processor |
| arm_valid | input | 1 | Arm command strobe |
| arm_count | input | CNT_W | Requested window length in cycles |
| query_valid | input | 1 | Query command strobe |
| rsp_valid | output | 1 | Query answer strobe, one cycle after the query |
| rsp_active | output | 1 | Query answer: 1 if the window was open |

## Verification
On every cycle, the assertions check four things:
- The counter stays within the clamp limit.
- Each arm command loads the clamped count, and the counter counts down by exactly one otherwise.
- The outputs are all low whenever the counter is nonzero, and equal to the inputs whenever it is zero.
- Every query gets exactly one answer that reflects the counter at the sampling edge.

Only the bench scenarios can show the end-to-end durations:
- The exact number of masked cycles after an arm, a reload and a clamped arm.
- The exact cycle in which a request held during the window first appears.
- The ordering when an arm and a query land on the same edge.

// File: rtl/irq_gate_pkg.sv
package irq_gate_pkg;

    // Window control states
    typedef enum logic [0:0] {
        GS_IDLE   = 1'b0,
        GS_MASKED = 1'b1
    } gate_state_e;

endpackage

// File: rtl/window_fsm.sv
module window_fsm
    import irq_gate_pkg::*;
#(
    parameter int CNT_W      = 8,
    parameter int MAX_WINDOW = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             arm_valid,
    input  logic [CNT_W-1:0] arm_count,
    output logic             window_open,
    output logic [CNT_W-1:0] remaining
);

    localparam logic [CNT_W-1:0] LIMIT = CNT_W'(MAX_WINDOW);
    localparam logic [CNT_W-1:0] ONE   = CNT_W'(1);

    gate_state_e      state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic [CNT_W-1:0] clamped;

    // Ceiling on what an unprivileged task can request
    assign clamped = (arm_count > LIMIT) ? LIMIT : arm_count;

    // State and counter register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= GS_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // Next-state and counter logic
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            GS_IDLE: begin
                if (arm_valid && (clamped != '0)) begin
                    state_d = GS_MASKED;          // ARM
                    cnt_d   = clamped;
                end
            end
            GS_MASKED: begin
                if (arm_valid) begin
                    cnt_d = clamped;
                    if (clamped != '0) begin
                        state_d = GS_MASKED;      // RELOAD
                    end else begin
                        state_d = GS_IDLE;        // CANCEL
                    end
                end else if (cnt_q == ONE) begin
                    state_d = GS_IDLE;            // EXPIRE
                    cnt_d   = '0;
                end else begin
                    cnt_d = cnt_q - ONE;          // TICK
                end
            end
            default: begin
                state_d = GS_IDLE;
                cnt_d   = '0;
            end
        endcase
    end

    // Outputs
    always_comb begin
        window_open = (state_q == GS_MASKED);
        remaining   = cnt_q;
    end

endmodule

// File: rtl/line_gate.sv
module line_gate #(
    parameter int N_LINES = 32
) (
    input  logic               window_open,
    input  logic [N_LINES-1:0] irq_in,
    output logic [N_LINES-1:0] irq_out
);

    for (genvar i = 0; i < N_LINES; i++) begin : g_line
        assign irq_out[i] = irq_in[i] & ~window_open;
    end

endmodule

// File: rtl/query_reply.sv
module query_reply (
    input  logic clk,
    input  logic rst_n,
    input  logic query_valid,
    input  logic window_open,
    output logic rsp_valid,
    output logic rsp_active
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid  <= 1'b0;
            rsp_active <= 1'b0;
        end else begin
            rsp_valid  <= query_valid;
            rsp_active <= query_valid & window_open;
        end
    end

endmodule

// File: rtl/irq_mask_gate.sv
module irq_mask_gate #(
    parameter int N_LINES    = 32,
    parameter int CNT_W      = 8,
    parameter int MAX_WINDOW = 64
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_LINES-1:0] irq_in,
    output logic [N_LINES-1:0] irq_out,
    input  logic               arm_valid,
    input  logic [CNT_W-1:0]   arm_count,
    input  logic               query_valid,
    output logic               rsp_valid,
    output logic               rsp_active
);

    logic             win_open;
    logic [CNT_W-1:0] win_remaining;

    window_fsm #(
        .CNT_W      (CNT_W),
        .MAX_WINDOW (MAX_WINDOW)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .arm_valid   (arm_valid),
        .arm_count   (arm_count),
        .window_open (win_open),
        .remaining   (win_remaining)
    );

    line_gate #(
        .N_LINES (N_LINES)
    ) u_gate (
        .window_open (win_open),
        .irq_in      (irq_in),
        .irq_out     (irq_out)
    );

    query_reply u_query (
        .clk         (clk),
        .rst_n       (rst_n),
        .query_valid (query_valid),
        .window_open (win_open),
        .rsp_valid   (rsp_valid),
        .rsp_active  (rsp_active)
    );

endmodule

// File: rtl/irq_gate_checker.sv
module irq_gate_checker #(
    parameter int N_LINES    = 32,
    parameter int CNT_W      = 8,
    parameter int MAX_WINDOW = 64
) (
    input logic               clk,
    input logic               rst_n,
    input logic [N_LINES-1:0] irq_in,
    input logic [N_LINES-1:0] irq_out,
    input logic               arm_valid,
    input logic [CNT_W-1:0]   arm_count,
    input logic               query_valid,
    input logic               rsp_valid,
    input logic               rsp_active,
    input logic [CNT_W-1:0]   remaining
);

    localparam logic [CNT_W-1:0] LIMIT = CNT_W'(MAX_WINDOW);

    p_pass_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (remaining == '0) |-> (irq_out == irq_in));

    p_block_open_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (remaining != '0) |-> (irq_out == '0));

    p_zero_arm_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (arm_valid && arm_count == '0) |=> (remaining == '0));

    p_reload_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (arm_valid && arm_count != '0 && arm_count <= LIMIT) |=> (remaining == $past(arm_count)));

    p_no_overflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
        remaining <= LIMIT);

    p_clamp_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (arm_valid && arm_count > LIMIT) |=> (remaining == LIMIT));

    p_countdown_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!arm_valid && remaining != '0) |=> (remaining == $past(remaining) - CNT_W'(1)));

    p_answer_r6: assert property (@(posedge clk) disable iff (!rst_n)
        query_valid |=> (rsp_valid && (rsp_active == ($past(remaining) != '0))));

    p_silent_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !query_valid |=> !rsp_valid);

endmodule

bind irq_mask_gate irq_gate_checker #(
    .N_LINES    (N_LINES),
    .CNT_W      (CNT_W),
    .MAX_WINDOW (MAX_WINDOW)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .irq_in      (irq_in),
    .irq_out     (irq_out),
    .arm_valid   (arm_valid),
    .arm_count   (arm_count),
    .query_valid (query_valid),
    .rsp_valid   (rsp_valid),
    .rsp_active  (rsp_active),
    .remaining   (win_remaining)
);

// File: tb/irq_mask_gate_bench.sv
module irq_mask_gate_bench;

    localparam int N_LINES    = 32;
    localparam int CNT_W      = 8;
    localparam int MAX_WINDOW = 64;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic [N_LINES-1:0] irq_in = '0;
    logic [N_LINES-1:0] irq_out;
    logic               arm_valid = 1'b0;
    logic [CNT_W-1:0]   arm_count = '0;
    logic               query_valid = 1'b0;
    logic               rsp_valid;
    logic               rsp_active;

    int checks = 0;
    int failures = 0;
    bit exp_q[$];

    always #5 clk = ~clk;

    irq_mask_gate #(
        .N_LINES    (N_LINES),
        .CNT_W      (CNT_W),
        .MAX_WINDOW (MAX_WINDOW)
    ) u_irq_mask_gate (
        .clk         (clk),
        .rst_n       (rst_n),
        .irq_in      (irq_in),
        .irq_out     (irq_out),
        .arm_valid   (arm_valid),
        .arm_count   (arm_count),
        .query_valid (query_valid),
        .rsp_valid   (rsp_valid),
        .rsp_active  (rsp_active)
    );

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Driver: one command cycle, entered and left at a falling edge
    task automatic drive(input bit arm, input int cnt, input bit qry, input bit exp_active);
        arm_valid   = arm;
        arm_count   = CNT_W'(cnt);
        query_valid = qry;
        if (qry) exp_q.push_back(exp_active);
        @(negedge clk);
        arm_valid   = 1'b0;
        query_valid = 1'b0;
    endtask

    // Counts consecutive masked cycles while irq_in is nonzero
    task automatic measure(output int n);
        n = 0;
        while (irq_out == '0 && n < 300) begin
            n++;
            @(negedge clk);
        end
    endtask

    // Monitor: pops expected query answers
    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R6 unexpected answer", 1, 0);
            end else begin
                bit e;
                e = exp_q.pop_front();
                check(rsp_active == e, "R6 query answer", rsp_active, e);
            end
        end
    end

    initial begin
        #(200000 * 10);
        check(1'b0, "watchdog", 0, 1);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int n;
        irq_in = 32'hA5A5_0F0F;
        repeat (3) @(negedge clk);
        check(irq_out == irq_in, "R8 reset pass", irq_out, irq_in);
        check(rsp_valid == 1'b0, "R8 rsp idle", rsp_valid, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(irq_out == irq_in, "R8 after reset", irq_out, irq_in);

        // R1 pass-through for several patterns
        irq_in = 32'h8000_0001; #1;
        check(irq_out == irq_in, "R1 pattern a", irq_out, irq_in);
        irq_in = 32'hFFFF_FFFF; #1;
        check(irq_out == irq_in, "R1 pattern b", irq_out, irq_in);
        irq_in = 32'h0000_0000; #1;
        check(irq_out == irq_in, "R1 pattern c", irq_out, irq_in);
        @(negedge clk);

        // R2 basic window of 5
        irq_in = 32'hFFFF_0000;
        drive(1'b1, 5, 1'b0, 1'b0);
        measure(n);
        check(n == 5, "R2 window length", n, 5);
        check(irq_out == irq_in, "R2 lines return", irq_out, irq_in);

        // R3 zero count arms nothing
        drive(1'b1, 0, 1'b0, 1'b0);
        check(irq_out == irq_in, "R3 no mask", irq_out, irq_in);
        drive(1'b0, 0, 1'b1, 1'b0);
        @(negedge clk);

        // R4 reload during window
        drive(1'b1, 20, 1'b0, 1'b0);
        repeat (5) @(negedge clk);
        drive(1'b1, 3, 1'b0, 1'b0);
        measure(n);
        check(n == 3, "R4 reload length", n, 3);

        // R4 cancel with zero
        drive(1'b1, 9, 1'b0, 1'b0);
        @(negedge clk);
        drive(1'b1, 0, 1'b0, 1'b0);
        check(irq_out == irq_in, "R4 cancel", irq_out, irq_in);

        // R5 clamp
        drive(1'b1, 200, 1'b0, 1'b0);
        measure(n);
        check(n == MAX_WINDOW, "R5 clamp length", n, MAX_WINDOW);
        drive(1'b1, MAX_WINDOW, 1'b0, 1'b0);
        measure(n);
        check(n == MAX_WINDOW, "R5 limit exact", n, MAX_WINDOW);

        // R6 query inside and after window
        drive(1'b1, 10, 1'b0, 1'b0);
        @(negedge clk);
        drive(1'b0, 0, 1'b1, 1'b1);
        repeat (12) @(negedge clk);
        drive(1'b0, 0, 1'b1, 1'b0);
        @(negedge clk);
        check(rsp_valid == 1'b0, "R6 single answer", rsp_valid, 0);

        // R9 arm and query on the same edge
        drive(1'b1, 8, 1'b1, 1'b0);
        drive(1'b0, 0, 1'b1, 1'b1);
        repeat (10) @(negedge clk);

        // R7 request raised mid-window appears right after
        irq_in = '0;
        drive(1'b1, 6, 1'b0, 1'b0);
        repeat (2) @(negedge clk);
        irq_in = 32'h0000_0100;
        repeat (3) @(negedge clk);
        check(irq_out == '0, "R7 held last cycle", irq_out, 0);
        @(negedge clk);
        check(irq_out == 32'h0000_0100, "R7 released", irq_out, 32'h100);

        repeat (3) @(negedge clk);
        check(exp_q.size() == 0, "R6 all answered", exp_q.size(), 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule